// File: doc/BRIEF.md
# Palette-Translated Scanout with Dirty-Row Skipping

This block reads an 8-bit indexed framebuffer one row at a time, in row-major order, for a frame size chosen at run time. Each pixel byte goes to an external palette, which returns red, green and blue. The block packs these into a 32-bit word with a zero top byte and sends it on a valid/ready pixel stream. Rows that have not changed since the last frame are skipped without any memory reads.

Row changes are reported on a mark port, one row index per cycle, and stored in a pending vector. When a frame starts, that vector is copied into a per-frame snapshot and then cleared, so marks made during scanout count toward the next frame. A full-refresh flag selects every row. The flag is set at reset and by request, and it clears when a frame completes. Each run of adjacent converted rows is reported once as a region: its start row, its row count and the frame width, with the left edge always at column zero. A one-cycle frame-done pulse closes every frame.

The framebuffer and the palette both sit outside the block. Each has a synchronous read port whose data arrives one cycle after the read strobe.

Top module: `idxscan_top`

## Requirements
- R1: After reset, pix_valid, rect_valid, frame_done, mem_rd and pal_rd are low, and the full-refresh flag is set, so the first frame converts every row.
- R2: The pixel at column x of row y is read from byte address y*W + x, where W is the latched width. Within a row, x runs from 0 to W-1, and rows are visited in ascending order.
- R3: Each output word is {8'h00, R, G, B}, where R, G and B are the palette's answer for the byte read at that pixel's address. Words leave in the order of their addresses.
- R4: A row y < H is converted when the full-refresh flag was set at frame start or its bit is set in the snapshot. Any other row produces no memory read and no pixel.
- R5: Each maximal run of converted rows gives exactly one rect_valid pulse. The pulse carries rect_y (the first row of the run), rect_h (the run length) and rect_w (W). It is issued when the first unconverted row or the end of the frame is reached, and regions come out in ascending row order.
- R6: The full-refresh flag is set by a full_req pulse and cleared in the cycle the frame completes, unless full_req is high in that same cycle.
- R7: On frame_start, the pending marks are copied to the snapshot and cleared. A mark made during scanout does not affect the frame in progress and selects its row in the next frame.
- R8: While pix_valid is high and pix_ready is low, pix_valid stays high and pix_data holds its value.
- R9: Every frame produces exactly one frame_done pulse, one cycle long, after its last region pulse. If W or H is zero, the frame produces frame_done with no region and no pixel.
- R10: W and H are taken from cfg_width and cfg_height on frame_start. Later changes on those inputs have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a frame; honoured only while idle |
| cfg_width | input | WW | Frame width in pixels |
| cfg_height | input | HW | Frame height in rows |
| full_req | input | 1 | Sets the full-refresh flag |
| mark_en | input | 1 | Marks row mark_row as changed |
| mark_row | input | RW | Row index to mark |
| mem_rd | output | 1 | Framebuffer read strobe |
| mem_addr | output | AW | Framebuffer byte address |
| mem_rdata | input | 8 | Framebuffer byte, valid one cycle after mem_rd |
| pal_rd | output | 1 | Palette read strobe |
| pal_idx | output | 8 | Palette index |
| pal_r | input | 8 | Red component, valid one cycle after pal_rd |
| pal_g | input | 8 | Green component, valid one cycle after pal_rd |
| pal_b | input | 8 | Blue component, valid one cycle after pal_rd |
| pix_valid | output | 1 | Pixel word valid |
| pix_ready | input | 1 | Sink accepts pixel word |
| pix_data | output | 32 | Pixel word {8'h00, R, G, B} |
| rect_valid | output | 1 | Region report strobe |
| rect_y | output | HW | First row of region |
| rect_h | output | HW | Row count of region |
| rect_w | output | WW | Region width (always W; left edge is column 0) |
| frame_done | output | 1 | One-cycle frame completion pulse |

## Verification
The assertions rely on four conditions:
- The framebuffer and the palette return data exactly one cycle after their strobes, and they never stall.
- frame_start is pulsed only while the block is idle.
- The configured dimensions do not exceed MAX_W and MAX_H.
- Marked rows are below MAX_H.

The bench models both memories as one-cycle registered functions of the address or index. It pulses frame_start only after it has seen the previous frame_done, drives dimensions within range, and marks only rows below MAX_H. After every frame_start it also writes unrelated values to the configuration inputs.

// File: rtl/idxscan_pkg.sv
package idxscan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_FETCH,
    ST_INDEX,
    ST_LOOK,
    ST_CAPT,
    ST_SEND,
    ST_DONE
  } scan_state_t;
endpackage

// File: rtl/idxscan_dirty.sv
module idxscan_dirty #(
  parameter int MAX_H = 8,
  parameter int RW = 3,
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mark_en,
  input  logic [RW-1:0] mark_row,
  input  logic          full_req,
  input  logic          snap_en,
  input  logic          clr_full,
  input  logic [HW-1:0] sel_row,
  output logic          row_hit
);
  logic [MAX_H-1:0] pend_q;
  logic [MAX_H-1:0] snap_q;
  logic [MAX_H-1:0] mark_vec;
  logic             full_q;

  always_comb begin
    for (int i = 0; i < MAX_H; i++) begin
      mark_vec[i] = mark_en && (mark_row == RW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      snap_q <= '0;
      full_q <= 1'b1;
    end else begin
      if (snap_en) begin
        snap_q <= full_q ? '1 : pend_q;
        pend_q <= mark_vec;
      end else begin
        pend_q <= pend_q | mark_vec;
      end
      if (full_req) begin
        full_q <= 1'b1;
      end else if (clr_full) begin
        full_q <= 1'b0;
      end
    end
  end

  assign row_hit = (sel_row < HW'(MAX_H)) ? snap_q[sel_row[RW-1:0]] : 1'b0;

  // R6
  full_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_full && !full_req) |=> !full_q);

  // R7
  snap_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (snap_en && !mark_en) |=> (pend_q == '0));
endmodule

// File: rtl/idxscan_runs.sv
module idxscan_runs #(
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          row_ev,
  input  logic          row_hit,
  input  logic [HW-1:0] row_y,
  output logic          rect_valid,
  output logic [HW-1:0] rect_y,
  output logic [HW-1:0] rect_h
);
  logic          open_q;
  logic [HW-1:0] start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q     <= 1'b0;
      start_q    <= '0;
      rect_valid <= 1'b0;
      rect_y     <= '0;
      rect_h     <= '0;
    end else begin
      rect_valid <= 1'b0;
      if (row_ev) begin
        if (row_hit) begin
          if (!open_q) begin
            open_q  <= 1'b1;
            start_q <= row_y;
          end
        end else if (open_q) begin
          open_q     <= 1'b0;
          rect_valid <= 1'b1;
          rect_y     <= start_q;
          rect_h     <= row_y - start_q;
        end
      end
    end
  end

  // R5
  rect_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    rect_valid |-> (rect_h != '0));

  // R5
  rect_single_chk: assert property (@(posedge clk) disable iff (rst)
    rect_valid |=> !rect_valid);
endmodule

// File: rtl/idxscan_top.sv
module idxscan_top #(
  parameter int MAX_W = 16,
  parameter int MAX_H = 8,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1),
  localparam int RW = (MAX_H > 1) ? $clog2(MAX_H) : 1,
  localparam int AW = $clog2(MAX_W * MAX_H)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic [WW-1:0] cfg_width,
  input  logic [HW-1:0] cfg_height,
  input  logic          full_req,
  input  logic          mark_en,
  input  logic [RW-1:0] mark_row,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          pal_rd,
  output logic [7:0]    pal_idx,
  input  logic [7:0]    pal_r,
  input  logic [7:0]    pal_g,
  input  logic [7:0]    pal_b,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic [31:0]   pix_data,
  output logic          rect_valid,
  output logic [HW-1:0] rect_y,
  output logic [HW-1:0] rect_h,
  output logic [WW-1:0] rect_w,
  output logic          frame_done
);
  import idxscan_pkg::*;

  scan_state_t   state_q;
  logic [WW-1:0] w_q, x_q;
  logic [HW-1:0] h_q, y_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    idx_q;
  logic          dirty_hit, row_sel, row_ev, snap_en, clr_full;

  assign row_ev   = (state_q == ST_ROW);
  assign snap_en  = (state_q == ST_IDLE) && frame_start;
  assign clr_full = (state_q == ST_DONE);
  assign row_sel  = (y_q < h_q) && dirty_hit;
  assign mem_rd   = (state_q == ST_FETCH);
  assign mem_addr = addr_q;
  assign pal_rd   = (state_q == ST_LOOK);
  assign pal_idx  = idx_q;
  assign rect_w   = w_q;

  idxscan_dirty #(.MAX_H(MAX_H), .RW(RW), .HW(HW)) dirty_i (
    .clk(clk), .rst(rst), .mark_en(mark_en), .mark_row(mark_row),
    .full_req(full_req), .snap_en(snap_en), .clr_full(clr_full),
    .sel_row(y_q), .row_hit(dirty_hit)
  );

  idxscan_runs #(.HW(HW)) runs_i (
    .clk(clk), .rst(rst), .row_ev(row_ev), .row_hit(row_sel), .row_y(y_q),
    .rect_valid(rect_valid), .rect_y(rect_y), .rect_h(rect_h)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      w_q        <= '0;
      h_q        <= '0;
      x_q        <= '0;
      y_q        <= '0;
      addr_q     <= '0;
      idx_q      <= '0;
      pix_valid  <= 1'b0;
      pix_data   <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (frame_start) begin
            w_q    <= cfg_width;
            h_q    <= cfg_height;
            x_q    <= '0;
            y_q    <= '0;
            addr_q <= '0;
            state_q <= (cfg_width == '0 || cfg_height == '0) ? ST_DONE : ST_ROW;
          end
        end
        ST_ROW: begin
          if (y_q == h_q) begin
            state_q <= ST_DONE;
          end else if (row_sel) begin
            x_q     <= '0;
            state_q <= ST_FETCH;
          end else begin
            y_q    <= y_q + HW'(1);
            addr_q <= addr_q + AW'(w_q);
          end
        end
        ST_FETCH: state_q <= ST_INDEX;
        ST_INDEX: begin
          idx_q   <= mem_rdata;
          state_q <= ST_LOOK;
        end
        ST_LOOK: state_q <= ST_CAPT;
        ST_CAPT: begin
          pix_data  <= {8'h00, pal_r, pal_g, pal_b};
          pix_valid <= 1'b1;
          state_q   <= ST_SEND;
        end
        ST_SEND: begin
          if (pix_ready) begin
            pix_valid <= 1'b0;
            addr_q    <= addr_q + AW'(1);
            if (x_q == w_q - WW'(1)) begin
              x_q     <= '0;
              y_q     <= y_q + HW'(1);
              state_q <= ST_ROW;
            end else begin
              x_q     <= x_q + WW'(1);
              state_q <= ST_FETCH;
            end
          end
        end
        ST_DONE: begin
          frame_done <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (int'(mem_addr) < int'(w_q) * int'(h_q)));

  // R3
  pal_order_chk: assert property (@(posedge clk) disable iff (rst)
    pal_rd |-> $past(mem_rd, 2));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (!pix_valid && !mem_rd && !rect_valid));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> ($stable(w_q) && $stable(h_q)));
endmodule

// File: tb/idxscan_top_tb_top.sv
module idxscan_top_tb_top;
  localparam int MAX_W = 16;
  localparam int MAX_H = 8;
  localparam int WW = $clog2(MAX_W + 1);
  localparam int HW = $clog2(MAX_H + 1);
  localparam int RW = $clog2(MAX_H);
  localparam int AW = $clog2(MAX_W * MAX_H);
  localparam int NV = 7;
  localparam int TW [NV] = '{4, 5, 3, 16, 2, 6, 1};
  localparam int TH [NV] = '{3, 8, 6, 8, 4, 5, 1};
  localparam int TF [NV] = '{0, 0, 0, 0, 1, 0, 0};
  localparam int TM [NV] = '{8'h00, 8'h69, 8'h00, 8'h81, 8'h02, 8'hF0, 8'h00};
  localparam int TS [NV] = '{0, 1, 0, 0, 1, 1, 0};

  logic clk = 0, rst = 1;
  logic frame_start = 0, full_req = 0, mark_en = 0, pix_ready = 1;
  logic [WW-1:0] cfg_width = '0;
  logic [HW-1:0] cfg_height = '0;
  logic [RW-1:0] mark_row = '0;
  logic mem_rd, pal_rd, pix_valid, rect_valid, frame_done;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = 0, pal_idx, pal_r = 0, pal_g = 0, pal_b = 0;
  logic [31:0] pix_data;
  logic [HW-1:0] rect_y, rect_h;
  logic [WW-1:0] rect_w;

  int checks = 0, errors = 0, done_cnt = 0, cyc = 0, stall_mode = 0;
  bit order_bad = 0, reported = 0, full_m = 1;
  bit [MAX_H-1:0] mask_m = '0;
  logic [31:0] pixq[$];
  int rqy[$], rqh[$], rqw[$];
  logic prev_hold = 0;
  logic [31:0] prev_data = 0;

  always #10 clk = ~clk;

  idxscan_top #(.MAX_W(MAX_W), .MAX_H(MAX_H)) dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .full_req(full_req), .mark_en(mark_en),
    .mark_row(mark_row), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .pal_rd(pal_rd), .pal_idx(pal_idx), .pal_r(pal_r),
    .pal_g(pal_g), .pal_b(pal_b), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .rect_valid(rect_valid), .rect_y(rect_y),
    .rect_h(rect_h), .rect_w(rect_w), .frame_done(frame_done)
  );

  function automatic logic [7:0] mem_byte(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [31:0] exp_word(int a);
    logic [7:0] i;
    i = mem_byte(a);
    return {8'h00, i ^ 8'h5A, i + 8'd1, ~i};
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_byte(int'(mem_addr));
    if (pal_rd) begin
      pal_r <= pal_idx ^ 8'h5A;
      pal_g <= pal_idx + 8'd1;
      pal_b <= ~pal_idx;
    end
  end

  always @(posedge clk) begin
    #2;
    cyc = cyc + 1;
    pix_ready = (stall_mode == 0) || (cyc % 3 == 0);
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_hold) check(pix_valid && pix_data == prev_data, "R8", "stall hold",
                           int'(pix_data), int'(prev_data));
      prev_hold = pix_valid && !pix_ready;
      prev_data = pix_data;
      if (pix_valid && pix_ready) pixq.push_back(pix_data);
      if (rect_valid) begin
        if (done_cnt != 0 || frame_done) order_bad = 1;
        rqy.push_back(int'(rect_y));
        rqh.push_back(int'(rect_h));
        rqw.push_back(int'(rect_w));
      end
      if (frame_done) done_cnt++;
    end
  end

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic mark(int r);
    @(negedge clk);
    mark_en = 1;
    mark_row = RW'(r);
    mask_m[r] = 1;
    @(negedge clk);
    mark_en = 0;
  endtask

  task automatic req_full();
    @(negedge clk);
    full_req = 1;
    full_m = 1;
    @(negedge clk);
    full_req = 0;
  endtask

  task automatic run_frame(int w, int h, int stall, int mid_row);
    bit [MAX_H-1:0] sel;
    logic [31:0] ep[$];
    int ey[$], eh[$];
    int t, rs;
    @(negedge clk);
    stall_mode = stall;
    cfg_width = WW'(w);
    cfg_height = HW'(h);
    frame_start = 1;
    pixq.delete(); rqy.delete(); rqh.delete(); rqw.delete();
    done_cnt = 0;
    order_bad = 0;
    for (int y = 0; y < MAX_H; y++) sel[y] = full_m || mask_m[y];
    mask_m = '0;
    @(negedge clk);
    frame_start = 0;
    cfg_width = WW'(7);
    cfg_height = HW'(2);
    if (mid_row >= 0) begin
      repeat (3) @(negedge clk);
      mark(mid_row);
    end
    t = 0;
    while (done_cnt == 0 && t < 6000) begin
      @(negedge clk);
      t++;
    end
    check(t < 6000, "R9", "frame completes", t, 0);
    repeat (3) @(negedge clk);
    full_m = 0;
    rs = -1;
    for (int y = 0; y <= h; y++) begin
      if (y < h && sel[y]) begin
        if (rs < 0) rs = y;
        for (int x = 0; x < w; x++) ep.push_back(exp_word(y * w + x));
      end else if (rs >= 0) begin
        ey.push_back(rs);
        eh.push_back(y - rs);
        rs = -1;
      end
    end
    if (w == 0) begin
      ey.delete();
      eh.delete();
    end
    check(pixq.size() == ep.size(), "R4", "pixel count", pixq.size(), ep.size());
    for (int i = 0; i < ep.size() && i < pixq.size(); i++)
      check(pixq[i] === ep[i], "R2 R3", "pixel word", int'(pixq[i]), int'(ep[i]));
    check(rqy.size() == ey.size(), "R5", "region count", rqy.size(), ey.size());
    for (int i = 0; i < ey.size() && i < rqy.size(); i++) begin
      check(rqy[i] == ey[i], "R5", "region start", rqy[i], ey[i]);
      check(rqh[i] == eh[i], "R5", "region rows", rqh[i], eh[i]);
      check(rqw[i] == w, "R10", "region width", rqw[i], w);
    end
    check(done_cnt == 1, "R9", "one done pulse", done_cnt, 1);
    check(!order_bad, "R9", "done after regions", int'(order_bad), 0);
  endtask

  initial begin
    #(20 * 200000);
    check(0, "WDOG", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: idle outputs after reset
    check(!pix_valid && !rect_valid && !frame_done, "R1", "outputs idle",
          {pix_valid, rect_valid, frame_done}, 0);
    check(!mem_rd && !pal_rd, "R1", "no reads", {mem_rd, pal_rd}, 0);

    // Vector table; entry 0 relies on the flag set at reset (R1, R6)
    for (int i = 0; i < NV; i++) begin
      if (TF[i] != 0) req_full();
      for (int r = 0; r < MAX_H; r++) if (TM[i][r]) mark(r);
      run_frame(TW[i], TH[i], TS[i], -1);
    end

    // R7: a mark during scanout goes to the next frame
    mark(1);
    run_frame(4, 4, 0, 3);
    run_frame(4, 4, 1, -1);

    // R9: zero width with a full refresh pending, then check the flag cleared (R6)
    req_full();
    run_frame(0, 4, 0, -1);
    run_frame(2, 2, 0, -1);
    // R9: zero height
    mark(0);
    run_frame(3, 0, 0, -1);
    mask_m = '0;
    run_frame(3, 2, 0, -1);
    summary();
  end
endmodule